// File: doc/BRIEF.md
# SECDED Protection Unit with Scrub Write-Back

This block guards 64-bit memory words with an extended Hamming code. On the write side it turns a data word into a 72-bit stored word: 64 data bits, 7 Hamming check bits and one overall parity bit. On the read side it takes a stored word together with its address. It corrects any single flipped bit and flags any double flip as uncorrectable. It then hands the data on through a one-entry register stage.

Each read that needed a correction makes the block raise a scrub request. The request carries the address and the repaired 72-bit word, so that the memory controller can write the clean copy back. Only one scrub waits at a time. A correction that arrives while the slot is full is dropped, and a sticky overflow flag is raised. Two saturating counters tally corrected and uncorrectable reads. A clear pulse resets both counters and the overflow flag.

The write path is a pass-through valid/ready stream with no storage. The read path is a valid/ready stream with a single register. A word is taken on a clock edge where `rd_in_valid` and `rd_in_ready` are both high. `rd_in_ready` is high when the output register is empty or is being drained in that cycle. Results stay stable while `rd_out_valid` is high and `rd_out_ready` is low.

Top module: `secded_scrub`

## Requirements
- R1: `enc_out_code` places bit position p (1..71) of the code at index p and the overall parity at index 0. Data bits fill the positions that are not powers of two, in ascending order, with data bit 0 at position 3. The check bit at position 2^b makes the XOR over all positions with bit b set even. Index 0 makes the whole 72-bit word even. `enc_out_valid` equals `enc_in_valid` and `enc_in_ready` equals `enc_out_ready`, both combinationally.
- R2: `rd_in_ready` is high exactly when `rd_out_valid` is low or `rd_out_ready` is high. A word accepted at a clock edge appears on the `rd_out_*` outputs after that edge and holds stable until it is taken.
- R3: A received word with zero syndrome and even overall parity is delivered unchanged, with `rd_out_fixed` and `rd_out_fatal` low.
- R4: A received word with exactly one flipped bit at positions 1..71 is delivered with the original data and `rd_out_fixed` high.
- R5: A received word whose only flipped bit is the overall parity bit (index 0) is delivered with unchanged data and `rd_out_fixed` high.
- R6: A received word with even overall parity and a nonzero syndrome, or with odd parity and a syndrome above 71, is delivered with `rd_out_fatal` high. Its data output is the data field of the received word with no correction applied. No scrub is issued for it.
- R7: When a fixed word is accepted and the scrub slot is free, `scrub_req` is high after that edge. `scrub_addr` holds the word's address and `scrub_code` holds the fully repaired 72-bit word. The slot is free when `scrub_req` is low or `scrub_ack` is high. The request holds until an edge where `scrub_ack` is high and then drops, unless a new scrub is loaded at that same edge.
- R8: A fixed word accepted while `scrub_req` is high and `scrub_ack` is low does not alter the pending scrub. It sets `scrub_ovf`, which stays high until a clear.
- R9: `cnt_fixed` adds one for each accepted fixed word and `cnt_fatal` adds one for each accepted fatal word. Both stop at 2^CNT_W-1.
- R10: `cnt_clr` sampled high makes both counters and `scrub_ovf` zero after that edge. The clear wins over an increment or overflow in the same cycle.
- R11: After reset, `rd_out_valid`, `scrub_req`, `scrub_ovf` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Write data offered |
| enc_in_ready | output | 1 | Write data taken |
| enc_in_data | input | 64 | Data word to encode |
| enc_out_valid | output | 1 | Stored word offered |
| enc_out_ready | input | 1 | Stored word taken |
| enc_out_code | output | 72 | Encoded stored word |
| rd_in_valid | input | 1 | Read word offered |
| rd_in_ready | output | 1 | Read word taken |
| rd_in_addr | input | ADDR_W | Address of read word |
| rd_in_code | input | 72 | Stored word as read |
| rd_out_valid | output | 1 | Decoded result held |
| rd_out_ready | input | 1 | Decoded result taken |
| rd_out_addr | output | ADDR_W | Address of result |
| rd_out_data | output | 64 | Decoded data |
| rd_out_fixed | output | 1 | A single error was corrected |
| rd_out_fatal | output | 1 | Uncorrectable error |
| scrub_req | output | 1 | Write-back pending |
| scrub_ack | input | 1 | Write-back taken |
| scrub_addr | output | ADDR_W | Write-back address |
| scrub_code | output | 72 | Repaired stored word |
| scrub_ovf | output | 1 | A scrub was dropped |
| cnt_clr | input | 1 | Clear counters and overflow |
| cnt_fixed | output | CNT_W | Corrected-error count |
| cnt_fatal | output | CNT_W | Uncorrectable-error count |

## Verification
The bench builds the block with CNT_W = 3 and ADDR_W = 8, so both counters reach their ceiling of 7 between clears. Saturation is therefore exercised again and again, as are clears that fall on the same cycle as an increment. With a slow, random scrub acknowledge, corrected words often arrive while a scrub is still pending, which drives the overflow path. Injected faults cover clean words, single flips at every position including the parity bit, double flips, and a triple flip whose syndrome points past position 71.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 7;
  localparam int CODE_W = DATA_W + CHK_W + 1;

  typedef enum logic [1:0] {
    KIND_CLEAN = 2'd0,
    KIND_FIXED = 2'd1,
    KIND_FATAL = 2'd2
  } err_kind_t;

  // position p>0 of the code is index p; index 0 is the overall parity
  function automatic logic [CODE_W-1:0] code_build(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    logic              acc;
    int                k;
    c = '0;
    k = 0;
    for (int pos = 1; pos < CODE_W; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        c[pos] = d[k];
        k++;
      end
    end
    for (int b = 0; b < CHK_W; b++) begin
      acc = 1'b0;
      for (int pos = 1; pos < CODE_W; pos++)
        if (pos[b]) acc = acc ^ c[pos];
      c[1 << b] = acc;
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic logic [CHK_W-1:0] code_syndrome(input logic [CODE_W-1:0] c);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int pos = 1; pos < CODE_W; pos++)
      if (c[pos]) s = s ^ pos[CHK_W-1:0];
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] code_extract(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] d;
    int                k;
    d = '0;
    k = 0;
    for (int pos = 1; pos < CODE_W; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        d[k] = c[pos];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  assign code_o = code_build(data_i);
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o,
  output err_kind_t         kind_o,
  output logic [CODE_W-1:0] repaired_o
);
  logic [CHK_W-1:0]  syn;
  logic              par_odd;
  logic [CODE_W-1:0] fixed;

  always_comb begin
    syn     = code_syndrome(code_i);
    par_odd = ^code_i;
    fixed   = code_i;
    if (!par_odd) begin
      kind_o = (syn == '0) ? KIND_CLEAN : KIND_FATAL;
    end else if (syn == '0) begin
      kind_o   = KIND_FIXED;
      fixed[0] = ~fixed[0];
    end else if (int'(syn) < CODE_W) begin
      kind_o     = KIND_FIXED;
      fixed[syn] = ~fixed[syn];
    end else begin
      kind_o = KIND_FATAL;
    end
  end

  assign repaired_o = fixed;
  assign data_o     = code_extract(fixed);
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (inc && q != TOP) q <= q + 1'b1;
  end
endmodule

// File: rtl/secded_scrub.sv
module secded_scrub
  import secded_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [63:0]       enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [71:0]       enc_out_code,
  input  logic              rd_in_valid,
  output logic              rd_in_ready,
  input  logic [ADDR_W-1:0] rd_in_addr,
  input  logic [71:0]       rd_in_code,
  output logic              rd_out_valid,
  input  logic              rd_out_ready,
  output logic [ADDR_W-1:0] rd_out_addr,
  output logic [63:0]       rd_out_data,
  output logic              rd_out_fixed,
  output logic              rd_out_fatal,
  output logic              scrub_req,
  input  logic              scrub_ack,
  output logic [ADDR_W-1:0] scrub_addr,
  output logic [71:0]       scrub_code,
  output logic              scrub_ovf,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  cnt_fixed,
  output logic [CNT_W-1:0]  cnt_fatal
);
  // write path: combinational pass-through
  secded_enc u_enc (.data_i(enc_in_data), .code_o(enc_out_code));
  assign enc_out_valid = enc_in_valid;
  assign enc_in_ready  = enc_out_ready;

  // read path
  logic [DATA_W-1:0] dec_data;
  logic [CODE_W-1:0] dec_fix;
  err_kind_t         dec_kind;

  secded_dec u_dec (
    .code_i    (rd_in_code),
    .data_o    (dec_data),
    .kind_o    (dec_kind),
    .repaired_o(dec_fix)
  );

  logic take, is_fixed, is_fatal, slot_free;
  assign rd_in_ready = !rd_out_valid || rd_out_ready;
  assign take        = rd_in_valid && rd_in_ready;
  assign is_fixed    = take && (dec_kind == KIND_FIXED);
  assign is_fatal    = take && (dec_kind == KIND_FATAL);
  assign slot_free   = !scrub_req || scrub_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_out_valid <= 1'b0;
      rd_out_fixed <= 1'b0;
      rd_out_fatal <= 1'b0;
      rd_out_addr  <= '0;
      rd_out_data  <= '0;
    end else if (take) begin
      rd_out_valid <= 1'b1;
      rd_out_fixed <= (dec_kind == KIND_FIXED);
      rd_out_fatal <= (dec_kind == KIND_FATAL);
      rd_out_addr  <= rd_in_addr;
      rd_out_data  <= dec_data;
    end else if (rd_out_ready) begin
      rd_out_valid <= 1'b0;
    end
  end

  // single scrub slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scrub_req  <= 1'b0;
      scrub_addr <= '0;
      scrub_code <= '0;
    end else if (is_fixed && slot_free) begin
      scrub_req  <= 1'b1;
      scrub_addr <= rd_in_addr;
      scrub_code <= dec_fix;
    end else if (scrub_ack) begin
      scrub_req  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_clr) scrub_ovf <= 1'b0;
    else if (is_fixed && !slot_free) scrub_ovf <= 1'b1;
  end

  // error statistics
  sat_cnt #(.W(CNT_W)) u_cnt_fixed (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(is_fixed), .q(cnt_fixed)
  );
  sat_cnt #(.W(CNT_W)) u_cnt_fatal (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(is_fatal), .q(cnt_fatal)
  );
endmodule

// File: rtl/secded_scrub_chk.sv
module secded_scrub_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_out_valid,
  input logic              rd_out_ready,
  input logic [ADDR_W-1:0] rd_out_addr,
  input logic [63:0]       rd_out_data,
  input logic              rd_out_fixed,
  input logic              rd_out_fatal,
  input logic              scrub_req,
  input logic              scrub_ack,
  input logic [ADDR_W-1:0] scrub_addr,
  input logic [71:0]       scrub_code,
  input logic              scrub_ovf,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  cnt_fixed,
  input logic [CNT_W-1:0]  cnt_fatal
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_valid && !rd_out_ready |=> rd_out_valid && $stable(rd_out_data) && $stable(rd_out_addr));

  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_valid |-> !(rd_out_fixed && rd_out_fatal));

  p_scrub_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req && !scrub_ack |=> scrub_req && $stable(scrub_addr) && $stable(scrub_code));

  p_scrub_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scrub_req) |-> rd_out_valid && rd_out_fixed && scrub_addr == rd_out_addr);

  p_scrub_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> !(^scrub_code));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_ovf && !cnt_clr |=> scrub_ovf);

  p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fixed == TOP && !cnt_clr |=> cnt_fixed == TOP);

  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt_fixed == '0 && cnt_fatal == '0 && !scrub_ovf);
endmodule

bind secded_scrub secded_scrub_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/secded_scrub_tb.sv
module secded_scrub_tb;
  localparam int AW = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic enc_in_valid, enc_in_ready, enc_out_valid, enc_out_ready;
  logic [63:0] enc_in_data;
  logic [71:0] enc_out_code;
  logic rd_in_valid, rd_in_ready, rd_out_valid, rd_out_ready;
  logic [AW-1:0] rd_in_addr, rd_out_addr, scrub_addr;
  logic [71:0] rd_in_code, scrub_code;
  logic [63:0] rd_out_data;
  logic rd_out_fixed, rd_out_fatal, scrub_req, scrub_ack, scrub_ovf, cnt_clr;
  logic [CW-1:0] cnt_fixed, cnt_fatal;

  secded_scrub #(.ADDR_W(AW), .CNT_W(CW)) u_dut (.*);

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input string what,
                     input logic [127:0] got, input logic [127:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic bit is_pow2(input int p);
    return (p == 1 || p == 2 || p == 4 || p == 8 || p == 16 || p == 32 || p == 64);
  endfunction

  // reference encoder: check bits are the XOR of the positions of set data bits
  function automatic logic [71:0] ref_enc(input logic [63:0] d);
    logic [71:0] w = '0;
    logic [6:0]  x = '0;
    int          k = 0;
    for (int p = 1; p < 72; p++) begin
      if (!is_pow2(p)) begin
        w[p] = d[k];
        if (d[k]) x = x ^ 7'(p);
        k++;
      end
    end
    for (int b = 0; b < 7; b++) w[1 << b] = x[b];
    w[0] = ^w;
    return w;
  endfunction

  function automatic logic [63:0] ref_ext(input logic [71:0] w);
    logic [63:0] d = '0;
    int          k = 0;
    for (int p = 1; p < 72; p++) begin
      if (!is_pow2(p)) begin
        d[k] = w[p];
        k++;
      end
    end
    return d;
  endfunction

  // reference model state
  logic          m_rv, m_fx, m_ft, m_sreq, m_ovf, m_clr_last;
  logic [63:0]   m_data;
  logic [AW-1:0] m_addr, m_saddr;
  logic [71:0]   m_scode;
  int            m_cf, m_cu;
  string         m_tag;

  // per-cycle stimulus descriptors
  int            c_kind;
  string         c_tag;
  logic [63:0]   c_exp_data;
  logic [71:0]   c_clean;

  localparam int TOPC = (1 << CW) - 1;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    enc_in_valid = 0; enc_out_ready = 0; enc_in_data = '0;
    rd_in_valid = 0; rd_out_ready = 0; rd_in_addr = '0; rd_in_code = '0;
    scrub_ack = 0; cnt_clr = 0;
    m_rv = 0; m_fx = 0; m_ft = 0; m_sreq = 0; m_ovf = 0; m_clr_last = 0;
    m_data = '0; m_addr = '0; m_saddr = '0; m_scode = '0;
    m_cf = 0; m_cu = 0; m_tag = "R3";
    c_kind = 0; c_tag = "R3"; c_exp_data = '0; c_clean = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11", "rd_out_valid", 128'(rd_out_valid), 128'(0));
    chk("R11", "scrub_req", 128'(scrub_req), 128'(0));
    chk("R11", "scrub_ovf", 128'(scrub_ovf), 128'(0));
    chk("R11", "cnt_fixed", 128'(cnt_fixed), 128'(0));
    chk("R11", "cnt_fatal", 128'(cnt_fatal), 128'(0));

    for (int cyc = 0; cyc < 4000; cyc++) begin
      // compare registered outputs against model
      if (cyc > 0) begin
        @(negedge clk);
        chk("R2", "rd_out_valid", 128'(rd_out_valid), 128'(m_rv));
        if (m_rv) begin
          chk(m_tag, "rd_out_data", 128'(rd_out_data), 128'(m_data));
          chk("R2", "rd_out_addr", 128'(rd_out_addr), 128'(m_addr));
          chk(m_tag, "rd_out_fixed", 128'(rd_out_fixed), 128'(m_fx));
          chk(m_tag, "rd_out_fatal", 128'(rd_out_fatal), 128'(m_ft));
        end
        chk("R7", "scrub_req", 128'(scrub_req), 128'(m_sreq));
        if (m_sreq) begin
          chk("R7", "scrub_addr", 128'(scrub_addr), 128'(m_saddr));
          chk("R7", "scrub_code", 128'(scrub_code), 128'(m_scode));
        end
        chk(m_clr_last ? "R10" : "R8", "scrub_ovf", 128'(scrub_ovf), 128'(m_ovf));
        chk(m_clr_last ? "R10" : "R9", "cnt_fixed", 128'(cnt_fixed), 128'(m_cf));
        chk(m_clr_last ? "R10" : "R9", "cnt_fatal", 128'(cnt_fatal), 128'(m_cu));
      end

      // new stimulus
      enc_in_valid  = ($urandom % 2) == 0;
      enc_out_ready = ($urandom % 2) == 0;
      enc_in_data   = {$urandom, $urandom};
      rd_in_valid   = ($urandom % 10) < 6;
      rd_out_ready  = ($urandom % 10) < 7;
      rd_in_addr    = AW'($urandom);
      scrub_ack     = m_sreq && (($urandom % 4) == 0);
      cnt_clr       = ($urandom % 80) == 0;
      c_exp_data    = {$urandom, $urandom};
      c_clean       = ref_enc(c_exp_data);
      c_kind        = int'($urandom % 6);
      rd_in_code    = c_clean;
      case (c_kind)
        2: begin
          int p = 1 + int'($urandom % 71);
          rd_in_code[p] = ~rd_in_code[p];
          c_tag = "R4";
        end
        3: begin
          rd_in_code[0] = ~rd_in_code[0];
          c_tag = "R5";
        end
        4: begin
          int a = int'($urandom % 72);
          int b = (a + 1 + int'($urandom % 71)) % 72;
          rd_in_code[a] = ~rd_in_code[a];
          rd_in_code[b] = ~rd_in_code[b];
          c_tag = "R6";
        end
        5: begin
          // syndrome 72 with odd parity: points past the word
          rd_in_code[0]  = ~rd_in_code[0];
          rd_in_code[8]  = ~rd_in_code[8];
          rd_in_code[64] = ~rd_in_code[64];
          c_tag = "R6";
        end
        default: c_tag = "R3";
      endcase
      if (c_kind >= 4) c_exp_data = ref_ext(rd_in_code);

      #1;
      chk("R2", "rd_in_ready", 128'(rd_in_ready), 128'(!m_rv || rd_out_ready));
      chk("R1", "enc_out_code", 128'(enc_out_code), 128'(ref_enc(enc_in_data)));
      chk("R1", "enc_out_valid", 128'(enc_out_valid), 128'(enc_in_valid));
      chk("R1", "enc_in_ready", 128'(enc_in_ready), 128'(enc_out_ready));

      // advance model at the edge using the driven inputs
      @(posedge clk);
      begin
        bit acc, fx, ft, free;
        acc  = rd_in_valid && (!m_rv || rd_out_ready);
        fx   = acc && (c_kind == 2 || c_kind == 3);
        ft   = acc && (c_kind >= 4);
        free = !m_sreq || scrub_ack;
        if (acc) begin
          m_rv   = 1'b1;
          m_data = c_exp_data;
          m_addr = rd_in_addr;
          m_fx   = (c_kind == 2 || c_kind == 3);
          m_ft   = (c_kind >= 4);
          m_tag  = c_tag;
        end else if (rd_out_ready) begin
          m_rv = 1'b0;
        end
        if (fx && free) begin
          m_sreq  = 1'b1;
          m_saddr = rd_in_addr;
          m_scode = c_clean;
        end else if (scrub_ack) begin
          m_sreq = 1'b0;
        end
        if (cnt_clr) begin
          m_ovf = 1'b0;
          m_cf  = 0;
          m_cu  = 0;
        end else begin
          if (fx && !free) m_ovf = 1'b1;
          if (fx && m_cf < TOPC) m_cf++;
          if (ft && m_cu < TOPC) m_cu++;
        end
        m_clr_last = cnt_clr;
      end
    end
    @(negedge clk);
    finish_run();
  end
endmodule